// File: doc/BRIEF.md
# ADC Output Code Formatter

This block sits between a 12-bit converter and the parallel output bus of a camera front end. Every clock it takes one converter word and emits a formatted word a fixed number of clocks later. Four codings are available: straight binary, Gray, and two differential forms. In the differential forms each word carries the modular difference from the word two clocks earlier, except for a pair of full reference words. The reference pair is placed at a selectable offset after the optical-black pulse, so that a downstream decoder can re-anchor its accumulation once per line.

After coding, the most significant bit and the lower bit field can each be inverted. While pre-blanking is active, the word is replaced by a clamp code derived from a 5-bit setting. The pre-blank input shares its polarity choice with the sampling pulses. The bus driver is modelled as a separate enable output, which drops whenever the output-enable pin is high or the front end is in standby.

Top module: `adc_code_fmt`

## Requirements
- R1: A word presented on `sample_in` before rising edge k appears on `data_out` just after edge k+LATENCY-1 (LATENCY = 12 by default), and `data_out` reads 0 during reset.
- R2: `code_mode` 2'b00 passes the word unchanged, and 2'b01 emits its Gray code, v XOR (v >> 1).
- R3: In `code_mode` 2'b10 a non-reference word is (word minus the word captured two clocks earlier) modulo 4096. In 2'b11 the Gray code of that difference is emitted. The word history reads zero after reset.
- R4: With `black_neg` = 0, number the word presented in the cycle where `black_pulse` first goes high as 0. Words 3+`ref_pos` and 4+`ref_pos` are then reference words carrying the full word (Gray coded in 2'b11). No reference word occurs before the first pulse.
- R5: With `black_neg` = 1 the pulse is sampled on the falling clock edge, and the reference pair moves one word earlier, to words 2+`ref_pos` and 3+`ref_pos`.
- R6: `inv_msb` = 1 flips bit 11 of the coded word, `inv_lsb` = 1 flips bits 10 to 0, and both together flip all 12 bits.
- R7: Pre-blanking is active when `preblank` XOR `pb_active_low` is 1. The word then becomes the clamp code 56 + 8*`clamp_sel`, with neither coding nor inversion applied, and it appears with the same latency as the data words.
- R8: `data_oe` is 0 whenever `oe_n` is 1 or `standby` is 1, and 1 otherwise, in the same cycle and independent of the data path.
- R9: A pulse held high for many clocks produces only one reference pair, and no more than two consecutive words are ever reference words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | DATA_W | Converter word |
| black_pulse | input | 1 | Optical-black pulse, active high |
| black_neg | input | 1 | 1: sample the pulse on the falling clock edge |
| ref_pos | input | 2 | Offset of the reference pair after the pulse |
| code_mode | input | 2 | 00 binary, 01 Gray, 10 differential binary, 11 differential Gray |
| inv_msb | input | 1 | Invert the top bit |
| inv_lsb | input | 1 | Invert the lower bit field |
| preblank | input | 1 | Pre-blank pulse |
| pb_active_low | input | 1 | 1: pre-blank is active low |
| clamp_sel | input | CLAMP_W | Clamp code setting |
| oe_n | input | 1 | Output disable pin, high disables |
| standby | input | 1 | Standby mode, disables the bus |
| data_out | output | DATA_W | Formatted word |
| data_oe | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach is the exact placement of the reference pair. It depends on the pulse's rise edge, on which clock edge samples the pulse, and on the 12-clock pipeline, all at once. The stimulus raises the pulse in a known cycle under each edge setting and several offsets, and surrounds it with descending word sequences so that the differences wrap modulo 4096. A reference word is then distinguishable from a difference word only at its exact position. A long pulse is also held to show that no second pair appears.

// File: rtl/adc_fmt_pkg.sv
`timescale 1ns/1ps
package adc_fmt_pkg;

  typedef enum logic [1:0] {
    CM_BIN   = 2'b00,
    CM_GRAY  = 2'b01,
    CM_DBIN  = 2'b10,
    CM_DGRAY = 2'b11
  } code_mode_e;

  // Reflected binary code of a zero-extended word.
  function automatic logic [31:0] gray_of(input logic [31:0] v);
    return v ^ (v >> 1);
  endfunction

  // Clamp code from its setting.
  function automatic logic [31:0] clamp_of(input logic [31:0] sel,
                                           input int unsigned base,
                                           input int unsigned step);
    return base + sel * step;
  endfunction

endpackage

// File: rtl/adc_fmt_refpos.sv
`timescale 1ns/1ps
module adc_fmt_refpos #(
  parameter int CNT_W    = 4,
  parameter int REF_BASE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       black_pulse,
  input  logic       black_neg,
  input  logic [1:0] ref_pos,
  output logic       ref_next
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             bp_pos, bp_neg, sel_q, sel, rise;
  logic [CNT_W-1:0] cnt, cnt_nxt, first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bp_pos <= 1'b0;
    else        bp_pos <= black_pulse;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) bp_neg <= 1'b0;
    else        bp_neg <= black_pulse;
  end

  assign sel  = black_neg ? bp_neg : bp_pos;
  assign rise = sel & ~sel_q;

  always_comb begin
    if (rise)                cnt_nxt = CNT_W'(1);
    else if (cnt == CNT_MAX) cnt_nxt = CNT_MAX;
    else                     cnt_nxt = cnt + CNT_W'(1);
  end

  assign first    = CNT_W'(REF_BASE) + CNT_W'(ref_pos);
  assign ref_next = (cnt_nxt == first) || (cnt_nxt == first + CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt   <= CNT_MAX;
    end else begin
      sel_q <= sel;
      cnt   <= cnt_nxt;
    end
  end

endmodule

// File: rtl/adc_fmt_encode.sv
`timescale 1ns/1ps
module adc_fmt_encode
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_in,
  input  logic [DATA_W-1:0] h2_in,
  input  logic              is_ref,
  input  logic              pb_act,
  input  logic [1:0]        mode,
  input  logic              inv_msb,
  input  logic              inv_lsb,
  input  logic [DATA_W-1:0] clamp_code,
  output logic [DATA_W-1:0] fmt_q
);

  code_mode_e        m;
  logic [DATA_W-1:0] delta, pick, coded, flip_mask, flipped, nxt;
  logic [31:0]       g_w;
  logic              diff_on;

  always_comb begin
    m         = code_mode_e'(mode);
    diff_on   = (m == CM_DBIN) || (m == CM_DGRAY);
    delta     = s_in - h2_in;
    pick      = (diff_on && !is_ref) ? delta : s_in;
    g_w       = gray_of(32'(pick));
    coded     = (m == CM_GRAY || m == CM_DGRAY) ? g_w[DATA_W-1:0] : pick;
    flip_mask = {inv_msb, {(DATA_W-1){inv_lsb}}};
    flipped   = coded ^ flip_mask;
    nxt       = pb_act ? clamp_code : flipped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_q <= '0;
    else        fmt_q <= nxt;
  end

endmodule

// File: rtl/adc_fmt_delay.sv
`timescale 1ns/1ps
module adc_fmt_delay #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out
);

  logic [DATA_W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[i] <= '0;
      else if (i == 0) stg[i] <= d_in;
      else             stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign d_out = stg[DEPTH-1];

endmodule

// File: rtl/adc_code_fmt.sv
`timescale 1ns/1ps
module adc_code_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LATENCY    = 12,
  parameter int CLAMP_W    = 5,
  parameter int CLAMP_BASE = 56,
  parameter int CLAMP_STEP = 8,
  parameter int CNT_W      = 4,
  parameter int REF_BASE   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  sample_in,
  input  logic               black_pulse,
  input  logic               black_neg,
  input  logic [1:0]         ref_pos,
  input  logic [1:0]         code_mode,
  input  logic               inv_msb,
  input  logic               inv_lsb,
  input  logic               preblank,
  input  logic               pb_active_low,
  input  logic [CLAMP_W-1:0] clamp_sel,
  input  logic               oe_n,
  input  logic               standby,
  output logic [DATA_W-1:0]  data_out,
  output logic               data_oe
);

  // Capture stage and formatting stage take two of the clocks.
  localparam int TAIL = LATENCY - 2;

  logic [DATA_W-1:0] s1, h1, h2, fmt_q, clamp_code;
  logic              pb1, ref1, ref_next;
  logic [31:0]       clamp_w;

  adc_fmt_refpos #(.CNT_W(CNT_W), .REF_BASE(REF_BASE)) u_refpos (
    .clk(clk), .rst_n(rst_n), .black_pulse(black_pulse),
    .black_neg(black_neg), .ref_pos(ref_pos), .ref_next(ref_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; h1 <= '0; h2 <= '0; pb1 <= 1'b0; ref1 <= 1'b0;
    end else begin
      s1   <= sample_in;
      h1   <= s1;
      h2   <= h1;
      pb1  <= preblank ^ pb_active_low;
      ref1 <= ref_next;
    end
  end

  assign clamp_w    = clamp_of(32'(clamp_sel), CLAMP_BASE, CLAMP_STEP);
  assign clamp_code = clamp_w[DATA_W-1:0];

  adc_fmt_encode #(.DATA_W(DATA_W)) u_encode (
    .clk(clk), .rst_n(rst_n), .s_in(s1), .h2_in(h2), .is_ref(ref1),
    .pb_act(pb1), .mode(code_mode), .inv_msb(inv_msb), .inv_lsb(inv_lsb),
    .clamp_code(clamp_code), .fmt_q(fmt_q)
  );

  adc_fmt_delay #(.DATA_W(DATA_W), .DEPTH(TAIL)) u_delay (
    .clk(clk), .rst_n(rst_n), .d_in(fmt_q), .d_out(data_out)
  );

  assign data_oe = ~(oe_n | standby);

endmodule

// File: rtl/adc_fmt_chk.sv
`timescale 1ns/1ps
module adc_fmt_chk
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int CLAMP_W    = 5,
  parameter int CLAMP_BASE = 56,
  parameter int CLAMP_STEP = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         code_mode,
  input logic               inv_msb,
  input logic               inv_lsb,
  input logic [CLAMP_W-1:0] clamp_sel,
  input logic               oe_n,
  input logic               standby,
  input logic               data_oe,
  input logic [DATA_W-1:0]  s1,
  input logic [DATA_W-1:0]  h2,
  input logic               pb1,
  input logic               ref1,
  input logic [DATA_W-1:0]  fmt_q
);

  localparam logic [31:0] DMASK = 32'((64'(1) << DATA_W) - 64'(1));

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || standby) |-> !data_oe); // R8

  AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !standby) |-> data_oe); // R8

  AST_REF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref1) |=> ref1); // R4

  AST_REF_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (ref1 && $past(ref1)) |=> !ref1); // R9

  AST_BLANK_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    pb1 |=> (32'(fmt_q) == (clamp_of(32'($past(clamp_sel)), CLAMP_BASE, CLAMP_STEP) & DMASK))); // R7

  AST_BIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_mode) == 2'b00 && !$past(pb1) && !$past(inv_msb) && !$past(inv_lsb))
      |-> (fmt_q == $past(s1))); // R2

  AST_DIFF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_mode) == 2'b10 && !$past(pb1) && !$past(ref1) && !$past(inv_msb) && !$past(inv_lsb))
      |-> (fmt_q == ($past(s1) - $past(h2)))); // R3

endmodule

bind adc_code_fmt adc_fmt_chk #(
  .DATA_W(DATA_W), .CLAMP_W(CLAMP_W), .CLAMP_BASE(CLAMP_BASE), .CLAMP_STEP(CLAMP_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .code_mode(code_mode), .inv_msb(inv_msb),
  .inv_lsb(inv_lsb), .clamp_sel(clamp_sel), .oe_n(oe_n), .standby(standby),
  .data_oe(data_oe), .s1(s1), .h2(h2), .pb1(pb1), .ref1(ref1), .fmt_q(fmt_q)
);

// File: tb/test_adc_code_fmt.sv
`timescale 1ns/1ps
module test_adc_code_fmt;

  localparam int LAT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sample_in = '0;
  logic        black_pulse = 1'b0, black_neg = 1'b0;
  logic [1:0]  ref_pos = 2'd0, code_mode = 2'd0;
  logic        inv_msb = 1'b0, inv_lsb = 1'b0;
  logic        preblank = 1'b0, pb_active_low = 1'b0;
  logic [4:0]  clamp_sel = 5'd0;
  logic        oe_n = 1'b0, standby = 1'b0;
  logic [11:0] data_out;
  logic        data_oe;

  adc_code_fmt i_adc_code_fmt (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .black_pulse(black_pulse),
    .black_neg(black_neg), .ref_pos(ref_pos), .code_mode(code_mode),
    .inv_msb(inv_msb), .inv_lsb(inv_lsb), .preblank(preblank),
    .pb_active_low(pb_active_low), .clamp_sel(clamp_sel), .oe_n(oe_n),
    .standby(standby), .data_out(data_out), .data_oe(data_oe)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, edge_cnt = 0;
  bit done = 1'b0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  typedef struct {
    int          due;
    logic [11:0] exp;
    bit          chk;
    string       req;
  } item_t;
  item_t sb[$];

  // Reference model state
  logic [11:0] prev1 = '0, prev2 = '0;
  int          idx = 0, j0 = -100;
  bit          pulse_prev = 1'b0;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] gray_b(input logic [11:0] b);
    logic [11:0] g;
    for (int i = 0; i < 11; i++) g[i] = b[i] ^ b[i+1];
    g[11] = b[11];
    return g;
  endfunction

  task automatic drive(input logic [11:0] s, input bit bp, input bit pb,
                       input bit chk, input string req);
    item_t it;
    int    rel, first;
    bit    isref;
    logic [11:0] v;
    if (bp && !pulse_prev) j0 = idx;
    rel   = idx - j0;
    first = 3 + int'(ref_pos) - (black_neg ? 1 : 0);
    isref = (rel == first) || (rel == first + 1);
    if (code_mode[1] && !isref) v = 12'((int'(s) + 4096 - int'(prev2)) % 4096);
    else                        v = s;
    if (code_mode[0]) v = gray_b(v);
    if (inv_msb) v[11] = ~v[11];
    if (inv_lsb) v[10:0] = ~v[10:0];
    if (pb ^ pb_active_low) v = 12'(56 + 8 * int'(clamp_sel));
    it.due = edge_cnt + LAT;
    it.exp = v;
    it.chk = chk;
    it.req = req;
    sb.push_back(it);
    sample_in   = s;
    black_pulse = bp;
    preblank    = pb;
    prev2 = prev1; prev1 = s; idx++; pulse_prev = bp;
    @(posedge clk); #1;
  endtask

  task automatic set_ctrl(input logic [1:0] m, input logic [1:0] rp, input bit neg,
                          input bit im, input bit il, input bit pbl, input logic [4:0] cs);
    drive(12'h000, 1'b0, 1'b0, 1'b0, "");
    code_mode = m; ref_pos = rp; black_neg = neg;
    inv_msb = im; inv_lsb = il; pb_active_low = pbl; clamp_sel = cs;
    drive(12'h000, 1'b0, 1'b0, 1'b0, "");
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == edge_cnt) begin
      item_t it;
      it = sb.pop_front();
      if (it.chk) check(it.req, data_out, it.exp);
    end
  end

  // Pulse scenario: quiet words, pulse for plen clocks, then descending words.
  task automatic pulse_run(input int plen, input string req);
    for (int i = 0; i < 4; i++) drive(12'(100 + 37 * i), 1'b0, 1'b0, 1'b1, req);
    for (int i = 0; i < 20; i++)
      drive(12'((4000 - 311 * i + 4096 * 4) % 4096), (i < plen), 1'b0, 1'b1, req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", data_out, 12'h000);            // reset value
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8", {11'd0, data_oe}, 12'h001);    // enabled after reset

    // R1/R2: binary pass-through, exact cycle
    for (int i = 0; i < 20; i++) drive(12'((i * 273 + 5) % 4096), 1'b0, 1'b0, 1'b1, "R1");
    // R2: Gray coding
    set_ctrl(2'b01, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0);
    for (int i = 0; i < 16; i++) drive(12'((i * 977 + 11) % 4096), 1'b0, 1'b0, 1'b1, "R2");
    // R3/R4: differential binary, rising-edge pulse, offset 0
    set_ctrl(2'b10, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0);
    pulse_run(3, "R4");
    // R3: differential Gray, offset 2, with wrapping differences
    set_ctrl(2'b11, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0);
    pulse_run(3, "R3");
    // R5: falling-edge pulse sampling, offset 3
    set_ctrl(2'b11, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0);
    pulse_run(3, "R5");
    set_ctrl(2'b10, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0);
    pulse_run(2, "R5");
    // R9: long pulse gives a single reference pair
    set_ctrl(2'b10, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0);
    pulse_run(14, "R9");
    // R6: inversion modes
    set_ctrl(2'b00, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0);
    for (int i = 0; i < 6; i++) drive(12'(i * 613 + 1), 1'b0, 1'b0, 1'b1, "R6");
    set_ctrl(2'b00, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0);
    for (int i = 0; i < 6; i++) drive(12'(i * 613 + 2), 1'b0, 1'b0, 1'b1, "R6");
    set_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0);
    for (int i = 0; i < 6; i++) drive(12'(i * 613 + 3), 1'b0, 1'b0, 1'b1, "R6");
    // R7: pre-blanking, active high, clamp setting 0 (56)
    set_ctrl(2'b11, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0);
    for (int i = 0; i < 8; i++) drive(12'(i * 401 + 7), 1'b0, (i >= 2 && i < 6), 1'b1, "R7");
    // R7: active low, clamp setting 31 (304)
    set_ctrl(2'b00, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd31);
    for (int i = 0; i < 8; i++) drive(12'(i * 401 + 9), 1'b0, (i < 3 || i > 5), 1'b1, "R7");
    // drain pipeline with pre-blank inactive
    for (int i = 0; i < LAT + 2; i++) drive(12'h000, 1'b0, 1'b1, 1'b0, "");

    // R8: output enable
    oe_n = 1'b1; #1;
    check("R8", {11'd0, data_oe}, 12'h000);
    oe_n = 1'b0; standby = 1'b1; #1;
    check("R8", {11'd0, data_oe}, 12'h000);
    standby = 1'b0; #1;
    check("R8", {11'd0, data_oe}, 12'h001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule